// File: doc/BRIEF.md
# Dual-Queue Conversion Sequencer

This block decides which input selection a shared data converter works on next. Two request queues feed it. The single queue carries one fixed input selection. The scan queue steps through a sixteen-entry table. An entry takes part in a pass only when its own include flag and the matching bit of an external mask are both set. Each issued conversion presents a positive input code, a negative input code, a configuration index, a compare-enable bit and an identifier on the converter-side outputs. These values stay held until the converter acknowledges with a one-cycle done pulse.

Each queue is armed by its own start command and disarmed by its own stop command. A trigger source is chosen per queue: the start command itself (immediate), a shared periodic timer, the rising edge of an external event line, or the falling edge of that line. A trigger launches one pass of the queue. In continuous mode the queue keeps repeating passes until it is stopped. Separate commands switch the timer on and off. At every conversion boundary the single queue normally wins. An optional tailgate setting instead holds single work back until the scan pass under way has finished.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `conv_req`, `single_active` and `scan_active` are all low.
- R2: With trigger code 0 (immediate) and once mode, a `single_start` pulse issues exactly one conversion. That conversion carries the single-input fields and ID 0x20, and afterwards `single_active` returns low.
- R3: A scan pass issues one conversion for every index i where `scan_mask[i]` and the entry's include flag are both 1. These go out in ascending index order with `conv_id` equal to i and the entry's stored fields. Ineligible entries are skipped.
- R4: A scan pass with no eligible entry issues no conversion and ends. In immediate once mode `scan_active` then returns low.
- R5: While `conv_req` is high it stays high, with stable `conv_id`, until the cycle in which `conv_done` is sampled high. It is low in the cycle after that.
- R6: In continuous mode (`scan_cont`=1) scan passes repeat back to back. `scan_stop` clears `scan_active` on the next edge and issues nothing more. The conversion already in flight still completes.
- R7: Trigger code 1 selects the timer. After `timer_on`, the timer fires once every `timer_period` clock cycles, and each firing starts one pass of an armed queue.
- R8: Trigger code 2 starts a pass on a rising edge of `evt_in` only. Trigger code 3 starts a pass on a falling edge only.
- R9: With `tailgate_en` low, a pending single request is issued at the next conversion boundary, ahead of the remaining scan entries.
- R10: With `tailgate_en` high, a pending single request is issued only after the scan pass under way has ended.
- R11: `timer_off` stops the timer from the next cycle, so a timer-triggered queue issues nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_start | input | 1 | Arm single queue (pulse) |
| single_stop | input | 1 | Disarm single queue (pulse) |
| scan_start | input | 1 | Arm scan queue (pulse) |
| scan_stop | input | 1 | Disarm scan queue (pulse) |
| timer_on | input | 1 | Enable periodic timer (pulse) |
| timer_off | input | 1 | Disable periodic timer (pulse) |
| timer_period | input | 16 | Timer period in clock cycles |
| evt_in | input | 1 | External event line |
| single_trig | input | 2 | Single trigger: 0 immediate, 1 timer, 2 rise, 3 fall |
| single_cont | input | 1 | Single queue continuous mode |
| tailgate_en | input | 1 | Defer single work to end of scan pass |
| scan_trig | input | 2 | Scan trigger, same coding as single |
| scan_cont | input | 1 | Scan queue continuous mode |
| scan_mask | input | 16 | Per-entry scan enable mask |
| single_pos | input | 8 | Single positive input code |
| single_neg | input | 8 | Single negative input code |
| single_cfg | input | 2 | Single configuration index |
| single_cmp | input | 1 | Single compare enable |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | 4 | Table entry index |
| tbl_pos | input | 8 | Entry positive input code |
| tbl_neg | input | 8 | Entry negative input code |
| tbl_cfg | input | 2 | Entry configuration index |
| tbl_cmp | input | 1 | Entry compare enable |
| tbl_incl | input | 1 | Entry include flag |
| conv_req | output | 1 | Conversion request to converter |
| conv_pos | output | 8 | Issued positive input code |
| conv_neg | output | 8 | Issued negative input code |
| conv_cfg | output | 2 | Issued configuration index |
| conv_cmp | output | 1 | Issued compare enable |
| conv_id | output | 6 | Entry index, or 0x20 for single |
| conv_done | input | 1 | Conversion finished (pulse) |
| single_active | output | 1 | Single pass pending or running |
| scan_active | output | 1 | Scan pass pending or running |

## Verification
Scan passes are run against several masks, with two table entries left out by their include flag. The masks are a lone low bit, a lone high bit, a sparse checkerboard, an empty mask, a full mask and a scattered pattern. These separate correct skipping and ordering from an off-by-one in the pointer, from treating the mask alone as the filter, and from a pass that hangs on an empty mask. A single request placed in the middle of a pass is then observed with tailgating off and on, which shows where priority goes at a boundary. Timer and event-edge triggering are measured by the spacing and count of the conversions they cause. Both edge polarities are applied to each edge setting.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int IN_W  = 8;
  localparam int CFG_W = 2;

  typedef enum logic [1:0] {
    TRIG_IMM  = 2'd0,
    TRIG_TMR  = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef struct packed {
    logic [IN_W-1:0]  pos;
    logic [IN_W-1:0]  neg;
    logic [CFG_W-1:0] cfg;
    logic             cmp;
    logic             incl;
  } entry_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             on,
  input  logic             off,
  input  logic [TMR_W-1:0] period,
  output logic             tick
);
  logic             en_q, en_n;
  logic [TMR_W-1:0] cnt_q, cnt_n;
  logic [TMR_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    tick    = en_q && (cnt_inc >= {1'b0, period});
    en_n    = en_q;
    if (on)  en_n = 1'b1;
    if (off) en_n = 1'b0;
    cnt_n   = (!en_q || tick) ? '0 : cnt_inc[TMR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_n;
      cnt_q <= cnt_n;
    end
  end

  p_timer_off_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    off |=> !tick);
endmodule

// File: rtl/seq_queue_ctrl.sv
module seq_queue_ctrl import seq_pkg::*; (
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  start,
  input  logic  stop,
  input  trig_e sel,
  input  logic  cont,
  input  logic  tick,
  input  logic  rise,
  input  logic  fall,
  input  logic  pass_end,
  output logic  run
);
  logic armed_q, armed_n, run_q, run_n, trig;

  always_comb begin
    trig = armed_q && (((sel == TRIG_TMR)  && tick) ||
                       ((sel == TRIG_RISE) && rise) ||
                       ((sel == TRIG_FALL) && fall));
    armed_n = armed_q;
    run_n   = run_q;
    if (pass_end && !cont) begin
      run_n = 1'b0;
      if (sel == TRIG_IMM) armed_n = 1'b0;
    end
    if (trig) run_n = 1'b1;
    if (start) begin
      armed_n = 1'b1;
      if (sel == TRIG_IMM) run_n = 1'b1;
    end
    if (stop) begin
      armed_n = 1'b0;
      run_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      armed_q <= armed_n;
      run_q   <= run_n;
    end
  end

  assign run = run_q;

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    stop |=> !run);
endmodule

// File: rtl/seq_scan_walk.sv
module seq_scan_walk import seq_pkg::*; #(
  parameter int N_ENT = 16
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     we,
  input  logic [$clog2(N_ENT)-1:0] waddr,
  input  entry_t                   wentry,
  input  logic [N_ENT-1:0]         mask,
  input  logic                     run,
  input  logic                     issue,
  input  logic                     pass_end,
  output logic                     found,
  output logic [$clog2(N_ENT)-1:0] idx,
  output entry_t                   sel_entry,
  output logic                     started
);
  localparam int AW = $clog2(N_ENT);
  localparam int PW = AW + 1;

  entry_t          tbl [N_ENT];
  logic [PW-1:0]   ptr_q, ptr_n;
  logic            started_q, started_n;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                      tbl[g] <= '0;
      else if (we && (waddr == AW'(g))) tbl[g] <= wentry;
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (mask[i] && tbl[i].incl && (PW'(i) >= ptr_q)) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
    sel_entry = tbl[idx];
  end

  always_comb begin
    ptr_n     = ptr_q;
    started_n = started_q;
    if (!run) begin
      ptr_n     = '0;
      started_n = 1'b0;
    end else if (issue) begin
      ptr_n     = {1'b0, idx} + 1'b1;
      started_n = 1'b1;
    end else if (pass_end) begin
      ptr_n     = '0;
      started_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      started_q <= 1'b0;
    end else begin
      ptr_q     <= ptr_n;
      started_q <= started_n;
    end
  end

  assign started = started_q;

  p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ptr_q <= PW'(N_ENT));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer import seq_pkg::*; #(
  parameter int N_ENT = 16,
  parameter int TMR_W = 16,
  parameter int ID_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     single_start,
  input  logic                     single_stop,
  input  logic                     scan_start,
  input  logic                     scan_stop,
  input  logic                     timer_on,
  input  logic                     timer_off,
  input  logic [TMR_W-1:0]         timer_period,
  input  logic                     evt_in,
  input  logic [1:0]               single_trig,
  input  logic                     single_cont,
  input  logic                     tailgate_en,
  input  logic [1:0]               scan_trig,
  input  logic                     scan_cont,
  input  logic [N_ENT-1:0]         scan_mask,
  input  logic [IN_W-1:0]          single_pos,
  input  logic [IN_W-1:0]          single_neg,
  input  logic [CFG_W-1:0]         single_cfg,
  input  logic                     single_cmp,
  input  logic                     tbl_we,
  input  logic [$clog2(N_ENT)-1:0] tbl_addr,
  input  logic [IN_W-1:0]          tbl_pos,
  input  logic [IN_W-1:0]          tbl_neg,
  input  logic [CFG_W-1:0]         tbl_cfg,
  input  logic                     tbl_cmp,
  input  logic                     tbl_incl,
  output logic                     conv_req,
  output logic [IN_W-1:0]          conv_pos,
  output logic [IN_W-1:0]          conv_neg,
  output logic [CFG_W-1:0]         conv_cfg,
  output logic                     conv_cmp,
  output logic [ID_W-1:0]          conv_id,
  input  logic                     conv_done,
  output logic                     single_active,
  output logic                     scan_active
);
  localparam int AW = $clog2(N_ENT);
  localparam logic [ID_W-1:0] SINGLE_ID = ID_W'(1) << (ID_W - 1);

  logic [1:0]  rs_q;
  logic        rst_ni, evt_q, rise, fall, tick;
  logic        single_run, scan_run, found, started;
  logic        single_ready, issue_single, issue_scan, scan_end;
  logic [AW-1:0] idx;
  entry_t      sel_entry, wentry;
  logic        req_q, req_n;
  entry_t      out_q, out_n;
  logic [ID_W-1:0] id_q, id_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= evt_in;
  end
  assign rise = evt_in && !evt_q;
  assign fall = !evt_in && evt_q;

  assign wentry = '{pos: tbl_pos, neg: tbl_neg, cfg: tbl_cfg, cmp: tbl_cmp, incl: tbl_incl};

  seq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_ni(rst_ni), .on(timer_on), .off(timer_off),
    .period(timer_period), .tick(tick));

  seq_queue_ctrl u_single_q (
    .clk(clk), .rst_ni(rst_ni), .start(single_start), .stop(single_stop),
    .sel(trig_e'(single_trig)), .cont(single_cont), .tick(tick),
    .rise(rise), .fall(fall), .pass_end(issue_single), .run(single_run));

  seq_queue_ctrl u_scan_q (
    .clk(clk), .rst_ni(rst_ni), .start(scan_start), .stop(scan_stop),
    .sel(trig_e'(scan_trig)), .cont(scan_cont), .tick(tick),
    .rise(rise), .fall(fall), .pass_end(scan_end), .run(scan_run));

  seq_scan_walk #(.N_ENT(N_ENT)) u_walk (
    .clk(clk), .rst_ni(rst_ni), .we(tbl_we), .waddr(tbl_addr), .wentry(wentry),
    .mask(scan_mask), .run(scan_run), .issue(issue_scan), .pass_end(scan_end),
    .found(found), .idx(idx), .sel_entry(sel_entry), .started(started));

  always_comb begin
    single_ready = single_run && !(tailgate_en && started);
    issue_single = !req_q && single_ready;
    issue_scan   = !req_q && !single_ready && scan_run && found;
    scan_end     = !req_q && !single_ready && scan_run && !found;
    req_n = req_q;
    out_n = out_q;
    id_n  = id_q;
    if (req_q && conv_done) req_n = 1'b0;
    if (issue_single) begin
      req_n = 1'b1;
      out_n = '{pos: single_pos, neg: single_neg, cfg: single_cfg, cmp: single_cmp, incl: 1'b1};
      id_n  = SINGLE_ID;
    end else if (issue_scan) begin
      req_n = 1'b1;
      out_n = sel_entry;
      id_n  = ID_W'(idx);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      out_q <= '0;
      id_q  <= '0;
    end else begin
      req_q <= req_n;
      out_q <= out_n;
      id_q  <= id_n;
    end
  end

  assign conv_req      = req_q;
  assign conv_pos      = out_q.pos;
  assign conv_neg      = out_q.neg;
  assign conv_cfg      = out_q.cfg;
  assign conv_cmp      = out_q.cmp;
  assign conv_id       = id_q;
  assign single_active = single_run;
  assign scan_active   = scan_run;

  p_hold_until_done_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_id) && $stable(conv_pos)));

  p_release_after_done_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (conv_req && conv_done) |=> !conv_req);

  p_tailgate_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!conv_req && tailgate_en && started) |=> !(conv_req && conv_id == SINGLE_ID));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_ni |=> !conv_req);
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
  logic clk, rst_n;
  logic single_start, single_stop, scan_start, scan_stop, timer_on, timer_off;
  logic [15:0] timer_period;
  logic evt_in, single_cont, tailgate_en, scan_cont;
  logic [1:0] single_trig, scan_trig;
  logic [15:0] scan_mask;
  logic [7:0] single_pos, single_neg, tbl_pos, tbl_neg;
  logic [1:0] single_cfg, tbl_cfg;
  logic single_cmp, tbl_we, tbl_cmp, tbl_incl;
  logic [3:0] tbl_addr;
  logic conv_req, conv_cmp, conv_done, single_active, scan_active;
  logic [7:0] conv_pos, conv_neg;
  logic [1:0] conv_cfg;
  logic [5:0] conv_id;

  conv_sequencer dut (
    .clk(clk), .rst_n(rst_n), .single_start(single_start), .single_stop(single_stop),
    .scan_start(scan_start), .scan_stop(scan_stop), .timer_on(timer_on),
    .timer_off(timer_off), .timer_period(timer_period), .evt_in(evt_in),
    .single_trig(single_trig), .single_cont(single_cont), .tailgate_en(tailgate_en),
    .scan_trig(scan_trig), .scan_cont(scan_cont), .scan_mask(scan_mask),
    .single_pos(single_pos), .single_neg(single_neg), .single_cfg(single_cfg),
    .single_cmp(single_cmp), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_pos(tbl_pos),
    .tbl_neg(tbl_neg), .tbl_cfg(tbl_cfg), .tbl_cmp(tbl_cmp), .tbl_incl(tbl_incl),
    .conv_req(conv_req), .conv_pos(conv_pos), .conv_neg(conv_neg), .conv_cfg(conv_cfg),
    .conv_cmp(conv_cmp), .conv_id(conv_id), .conv_done(conv_done),
    .single_active(single_active), .scan_active(scan_active));

  localparam int NV = 6;
  localparam logic [15:0] VMASK [NV] = '{16'h0001, 16'h8000, 16'hA5A5,
                                          16'h0000, 16'hFFFF, 16'h1248};
  localparam logic [15:0] INCL = 16'hFBDF;

  int tests, fails, n, cyc;
  bit r5_bad;
  logic [5:0] log_id [64];
  logic [7:0] log_pos [64];
  int log_cyc [64];

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (scan_active || single_active || conv_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // converter model: holds each request two cycles, then acknowledges
  initial begin
    logic [5:0] cap;
    conv_done = 1'b0;
    n = 0;
    r5_bad = 1'b0;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        if (n < 64) begin
          log_id[n] = conv_id; log_pos[n] = conv_pos; log_cyc[n] = cyc;
        end
        n++;
        cap = conv_id;
        @(negedge clk);
        if (!conv_req || conv_id != cap) r5_bad = 1'b1;
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        if (conv_req) r5_bad = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n0, n1, k;
    bit ok;
    cyc = 0; tests = 0; fails = 0;
    rst_n = 1'b0;
    {single_start, single_stop, scan_start, scan_stop, timer_on, timer_off} = '0;
    timer_period = 16'd20; evt_in = 1'b0;
    single_trig = 2'd0; single_cont = 1'b0; tailgate_en = 1'b0;
    scan_trig = 2'd0; scan_cont = 1'b0; scan_mask = '0;
    single_pos = 8'h5A; single_neg = 8'h33; single_cfg = 2'd2; single_cmp = 1'b1;
    tbl_we = 1'b0; tbl_addr = '0; tbl_pos = '0; tbl_neg = '0; tbl_cfg = '0;
    tbl_cmp = 1'b0; tbl_incl = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!conv_req, "R1 conv_req", int'(conv_req), 0);
    check(!scan_active && !single_active, "R1 queues idle",
          int'(scan_active) + int'(single_active), 0);

    for (int i = 0; i < 16; i++) begin
      tbl_we = 1'b1; tbl_addr = 4'(i); tbl_pos = 8'(3 * i + 1); tbl_neg = 8'(200 - i);
      tbl_cfg = 2'(i); tbl_cmp = i[0]; tbl_incl = INCL[i];
      @(negedge clk);
    end
    tbl_we = 1'b0;

    // R3 / R4: mask vectors, immediate once scan
    for (int v = 0; v < NV; v++) begin
      scan_mask = VMASK[v];
      n0 = n;
      scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
      wait_idle();
      ok = 1'b1; k = n0;
      for (int i = 0; i < 16; i++) begin
        if (VMASK[v][i] && INCL[i]) begin
          if (k >= n || log_id[k] != 6'(i) || log_pos[k] != 8'(3 * i + 1)) ok = 1'b0;
          k++;
        end
      end
      if (k != n) ok = 1'b0;
      check(ok, "R3 scan order and skipping", n - n0, k - n0);
      if (VMASK[v] == 16'h0000)
        check(n == n0 && !scan_active, "R4 empty pass", n - n0, 0);
    end

    // R2 single immediate once
    n0 = n;
    single_start = 1'b1; @(negedge clk); single_start = 1'b0;
    wait_idle();
    check(n == n0 + 1 && log_id[n0] == 6'h20 && log_pos[n0] == 8'h5A,
          "R2 single conversion id", int'(log_id[n0]), 32);
    check(!single_active, "R2 single queue idle", int'(single_active), 0);

    // R9 single takes priority at a boundary
    scan_mask = 16'h000F; n0 = n;
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    wait (n >= n0 + 1);
    @(negedge clk); single_start = 1'b1; @(negedge clk); single_start = 1'b0;
    wait_idle();
    check(n == n0 + 5 && log_id[n0 + 1] == 6'h20 && log_id[n0 + 2] == 6'd1,
          "R9 single ahead of scan entries", int'(log_id[n0 + 1]), 32);

    // R10 tailgating holds single until pass end
    tailgate_en = 1'b1; n0 = n;
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    wait (n >= n0 + 1);
    @(negedge clk); single_start = 1'b1; @(negedge clk); single_start = 1'b0;
    wait_idle();
    check(n == n0 + 5 && log_id[n0 + 4] == 6'h20 && log_id[n0 + 3] == 6'd3,
          "R10 single after scan pass", int'(log_id[n0 + 4]), 32);
    tailgate_en = 1'b0;

    // R6 continuous scan and stop during a conversion
    scan_mask = 16'h0003; scan_cont = 1'b1; n0 = n;
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    wait (n >= n0 + 5);
    @(negedge clk); scan_stop = 1'b1; @(negedge clk); scan_stop = 1'b0;
    wait_idle();
    check(n == n0 + 5 && log_id[n0 + 2] == 6'd0 && log_id[n0 + 3] == 6'd1 &&
          log_id[n0 + 4] == 6'd0, "R6 repeat then stop", n - n0, 5);
    check(!scan_active && !conv_req, "R6 queue idle after stop", int'(scan_active), 0);
    scan_cont = 1'b0;

    // R7 timer trigger spacing
    scan_mask = 16'h0001; scan_trig = 2'd1; timer_period = 16'd20; n0 = n;
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    timer_on = 1'b1; @(negedge clk); timer_on = 1'b0;
    wait (n >= n0 + 3);
    check(log_cyc[n0 + 2] - log_cyc[n0 + 1] == 20, "R7 timer period",
          log_cyc[n0 + 2] - log_cyc[n0 + 1], 20);
    @(negedge clk); timer_off = 1'b1; @(negedge clk); timer_off = 1'b0;
    repeat (10) @(negedge clk);
    n1 = n;
    repeat (60) @(negedge clk);
    check(n == n1, "R11 timer off", n - n1, 0);
    scan_stop = 1'b1; @(negedge clk); scan_stop = 1'b0;
    wait_idle();

    // R8 rising edge trigger
    scan_trig = 2'd2; n0 = n;
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    repeat (5) @(negedge clk);
    evt_in = 1'b1; repeat (20) @(negedge clk);
    evt_in = 1'b0; repeat (20) @(negedge clk);
    check(n == n0 + 1, "R8 rising edge only", n - n0, 1);
    scan_stop = 1'b1; @(negedge clk); scan_stop = 1'b0;

    // R8 falling edge trigger
    scan_trig = 2'd3; n0 = n;
    scan_start = 1'b1; @(negedge clk); scan_start = 1'b0;
    evt_in = 1'b1; repeat (20) @(negedge clk);
    n1 = n;
    evt_in = 1'b0; repeat (20) @(negedge clk);
    check(n1 == n0 && n == n0 + 1, "R8 falling edge only", n - n0, 1);
    scan_stop = 1'b1; @(negedge clk); scan_stop = 1'b0;
    wait_idle();

    check(!r5_bad && n > 0, "R5 request held until done", int'(r5_bad), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule